// File: doc/BRIEF.md
# Bridge Power State Controller

This block holds the power-management state of a two-bus bridge and acts on configuration writes to its two-bit power-state field. The bridge itself implements only the full-on state (D0) and the hot-off state (D3hot). The cold-off state (D3cold) is the loss of power, and the block leaves it only through its power-up reset. Requests for the intermediate states D1 and D2 are dropped without any effect. Any other transition not listed here is refused.

On entry to D3hot the block reports bus power state B2 for the secondary bus. If a board strap allows it, the block also tells the secondary clock generator to stop its clocks and hold them low. The strap is sampled once, at the moment of entry. A later write of D0 restores the clocks and bus state B0. The current state is held and returned for readback.

Top module: `bpsc_top`

## Requirements
- R1: While and after power-up reset (`rstN` low), `pwrState` reads 00 (D0), `secClkEn` is 1 and `busPwrState` is 00 (B0).
- R2: A write (`cfgWrEn` high) of 11 while in D0 moves the block to D3hot: `pwrState` reads 11 after that clock edge.
- R3: A write of 01 (D1) or 10 (D2) while in D0 is ignored: `pwrState` stays 00 and the other outputs do not change.
- R4: On entry to D3hot, `secClkEn` goes to 0 if `clkStopStrap` was 1 at the entry edge, and stays 1 if it was 0. `secClkEn` is 0 only in D3hot.
- R5: `busPwrState` reads 10 (B2) in D3hot and 00 (B0) in D0.
- R6: A write of 00 while in D3hot returns the block to D0 after that edge, with `secClkEn` at 1 and `busPwrState` at 00.
- R7: A write of 01 or 10 while in D3hot is ignored. So is any cycle with `cfgWrEn` low, whatever `cfgWrState` holds. A write of the current state leaves all outputs unchanged.
- R8: While the block stays in D3hot, changes of `clkStopStrap` do not change `secClkEn`.
- R9: A power-up reset taken from D3hot returns the block to D0 with clocks enabled and bus state B0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-up reset, active low |
| cfgWrEn | input | 1 | Configuration write strobe for the power-state field |
| cfgWrState | input | 2 | Requested state: 00 D0, 01 D1, 10 D2, 11 D3hot |
| clkStopStrap | input | 1 | Strap pin that permits stopping the secondary clocks |
| pwrState | output | 2 | Held power state for readback |
| secClkEn | output | 1 | Secondary clock enable; 0 stops the clocks and holds them low |
| busPwrState | output | 2 | Secondary bus power state: 00 B0, 10 B2 |

## Verification
The bench writes D1 and D2 requests in both implemented states. A design that decoded only one bit of the request would enter D3hot or fall back to D0 on these writes. It toggles the strap while D3hot is held and enters D3hot with the strap both high and low. A design that followed the strap live, or ignored it, would start or stop the clocks at the wrong time. It also issues writes with the strobe low, and takes a reset from D3hot, where a design holding stale gating would leave the clocks stopped after power-up.

// File: rtl/bpsc_pkg.sv
package bpsc_pkg;
  localparam int STATE_W = 2;
  localparam int BUS_W   = 2;

  typedef enum logic [STATE_W-1:0] {
    PS_D0    = 2'b00,
    PS_D1    = 2'b01,
    PS_D2    = 2'b10,
    PS_D3HOT = 2'b11
  } pwrState_e;

  localparam logic [BUS_W-1:0] BUS_B0 = 2'b00;
  localparam logic [BUS_W-1:0] BUS_B2 = 2'b10;

  typedef struct packed {
    logic goHot;
    logic goOn;
    logic stopClk;
  } ctrlStrobes_t;
endpackage

// File: rtl/bpsc_ctrl.sv
module bpsc_ctrl
  import bpsc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [STATE_W-1:0] wrState,
  input  logic               strap,
  input  pwrState_e          curState,
  output ctrlStrobes_t       strobes
);
  pwrState_e reqState;
  logic isMid;

  always_comb begin
    reqState        = pwrState_e'(wrState);
    isMid           = (reqState == PS_D1) || (reqState == PS_D2);
    strobes.goHot   = wrEn && (curState == PS_D0) && (reqState == PS_D3HOT);
    strobes.goOn    = wrEn && (curState == PS_D3HOT) && (reqState == PS_D0);
    strobes.stopClk = strobes.goHot && strap;
  end

  // R2: D3hot request from D0 is taken
  assert_enter_hot_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && curState == PS_D0 && wrState == 2'b11) |=> (curState == PS_D3HOT));

  // R3 / R7: intermediate requests never move the state
  assert_drop_mid_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && isMid) |=> $stable(curState));

  // R7: no strobe, no change
  assert_no_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn) |=> $stable(curState));

  // R6: D0 request from D3hot is taken
  assert_leave_hot_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && curState == PS_D3HOT && wrState == 2'b00) |=> (curState == PS_D0));
endmodule

// File: rtl/bpsc_datapath.sv
module bpsc_datapath
  import bpsc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  output pwrState_e        stateQ,
  output logic             clkEn,
  output logic [BUS_W-1:0] busState
);
  logic gateQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= PS_D0;
      gateQ  <= 1'b0;
    end else if (strobes.goHot) begin
      stateQ <= PS_D3HOT;
      gateQ  <= strobes.stopClk;
    end else if (strobes.goOn) begin
      stateQ <= PS_D0;
      gateQ  <= 1'b0;
    end
  end

  always_comb begin
    clkEn    = !gateQ;
    busState = (stateQ == PS_D3HOT) ? BUS_B2 : BUS_B0;
  end

  // R4: clocks are stopped only in D3hot
  assert_gate_only_hot_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEn) |-> (stateQ == PS_D3HOT));

  // R8: gating holds while D3hot is held
  assert_gate_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == PS_D3HOT && $past(stateQ) == PS_D3HOT) |-> $stable(gateQ));

  // R6: return to D0 always brings clocks back
  assert_on_clocks_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.goOn |=> (clkEn && stateQ == PS_D0));
endmodule

// File: rtl/bpsc_top.sv
module bpsc_top
  import bpsc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [STATE_W-1:0] cfgWrState,
  input  logic               clkStopStrap,
  output logic [STATE_W-1:0] pwrState,
  output logic               secClkEn,
  output logic [BUS_W-1:0]   busPwrState
);
  ctrlStrobes_t strobes;
  pwrState_e    curState;

  bpsc_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (cfgWrEn),
    .wrState  (cfgWrState),
    .strap    (clkStopStrap),
    .curState (curState),
    .strobes  (strobes)
  );

  bpsc_datapath i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .stateQ   (curState),
    .clkEn    (secClkEn),
    .busState (busPwrState)
  );

  assign pwrState = curState;
endmodule

// File: tb/test_bpsc_top.sv
module test_bpsc_top;
  logic clk = 1'b0;
  logic rstN, wrEn, strap;
  logic [1:0] wrState;
  logic [1:0] pwrState, busPwrState;
  logic secClkEn;
  int nPass = 0, nTotal = 0;
  bit done = 0;
  logic [1:0] expState;
  logic expGate;

  always #10 clk = ~clk;

  bpsc_top i_bpsc_top (
    .clk(clk), .rstN(rstN), .cfgWrEn(wrEn), .cfgWrState(wrState),
    .clkStopStrap(strap), .pwrState(pwrState), .secClkEn(secClkEn),
    .busPwrState(busPwrState)
  );

  function automatic logic [1:0] nextState(logic [1:0] cur, logic en, logic [1:0] req);
    if (en && cur == 2'b00 && req == 2'b11) return 2'b11;
    if (en && cur == 2'b11 && req == 2'b00) return 2'b00;
    return cur;
  endfunction

  function automatic logic [1:0] busFor(logic [1:0] st);
    return (st == 2'b11) ? 2'b10 : 2'b00;
  endfunction

  task automatic check(string tag, string what, logic [1:0] act, logic [1:0] exp);
    nTotal++;
    if (act === exp) nPass++;
    else $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
  endtask

  task automatic checkAll(string tag);
    check(tag, "pwrState", pwrState, expState);
    check(tag, "secClkEn", {1'b0, secClkEn}, {1'b0, !expGate});
    check(tag, "busPwrState", busPwrState, busFor(expState));
  endtask

  // called at a negedge: drive, let one edge pass, check at the next negedge
  task automatic step(logic en, logic [1:0] req, logic s, string tag);
    logic [1:0] ns;
    wrEn = en; wrState = req; strap = s;
    @(posedge clk);
    ns = nextState(expState, en, req);
    if (expState == 2'b00 && ns == 2'b11) expGate = s;
    else if (ns == 2'b00) expGate = 1'b0;
    expState = ns;
    @(negedge clk);
    checkAll(tag);
  endtask

  task automatic doReset(string tag);
    rstN = 1'b0; wrEn = 1'b0;
    @(posedge clk); @(negedge clk);
    expState = 2'b00; expGate = 1'b0;
    checkAll(tag);
    rstN = 1'b1;
    @(negedge clk);
    checkAll(tag);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      nTotal++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", nPass, nTotal);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrState = 2'b00; strap = 1'b0;
    expState = 2'b00; expGate = 1'b0;
    @(negedge clk);
    doReset("R1");
    step(1'b1, 2'b01, 1'b1, "R3");
    step(1'b1, 2'b10, 1'b1, "R3");
    step(1'b0, 2'b11, 1'b1, "R7");
    step(1'b1, 2'b00, 1'b1, "R7");
    step(1'b1, 2'b11, 1'b0, "R2");
    check("R4", "secClkEn strap low", {1'b0, secClkEn}, 2'b01);
    check("R5", "busPwrState hot", busPwrState, 2'b10);
    step(1'b0, 2'b00, 1'b1, "R8");
    step(1'b1, 2'b01, 1'b1, "R7");
    step(1'b1, 2'b10, 1'b0, "R7");
    step(1'b1, 2'b11, 1'b1, "R7");
    step(1'b1, 2'b00, 1'b0, "R6");
    step(1'b1, 2'b11, 1'b1, "R4");
    check("R4", "secClkEn strap high", {1'b0, secClkEn}, 2'b00);
    step(1'b0, 2'b00, 1'b0, "R8");
    step(1'b1, 2'b10, 1'b0, "R8");
    doReset("R9");
    step(1'b1, 2'b11, 1'b1, "R2");
    step(1'b1, 2'b00, 1'b1, "R6");
    check("R6", "secClkEn restored", {1'b0, secClkEn}, 2'b01);

    void'($urandom(32'd4711));
    for (int i = 0; i < 2000; i++) begin
      logic en, s;
      logic [1:0] req;
      string tag;
      en = $urandom_range(0, 3) != 0;
      req = 2'($urandom_range(0, 3));
      s = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 99) == 0) begin
        if (expState == 2'b11) doReset("R9");
        else doReset("R1");
        continue;
      end
      if (!en) tag = (expState == 2'b11) ? "R8" : "R7";
      else if (req == 2'b01 || req == 2'b10) tag = (expState == 2'b00) ? "R3" : "R7";
      else if (req == expState) tag = "R7";
      else if (req == 2'b11) tag = "R4";
      else tag = "R6";
      step(en, req, s, tag);
    end

    done = 1;
    $display("%0d/%0d checks passed", nPass, nTotal);
    $finish;
  end
endmodule